// File: doc/BRIEF.md
# Decode-Stage Branch Resolution and Hazard Control

This block settles conditional branches and direct jumps while the instruction is still in decode, in a five-stage in-order pipeline. For every instruction it computes the branch destination from the sequential PC and the immediate offset, and the jump destination from the upper PC bits and the instruction index. It compares the two branch operands for equality or inequality and chooses the next-PC source. The operands are taken from the register file or from a result forwarded out of the memory stage. A taken branch or a jump discards the one instruction that was fetched behind it.

When a branch needs a value that is not yet available, the block freezes the PC and the fetch/decode register and sends a bubble into execute. The branch is then evaluated again in the next cycle. This happens when an instruction in execute writes one of the branch sources, or when a load in the memory stage does. A load in execute that feeds the branch therefore holds the branch for two cycles. An ALU result feeds it after one. The block is purely combinational and sits between the decoder, the register file read ports and the PC and pipeline register enables.

Top module: `id_branch_unit`

## Requirements
- R1: `br_target` always equals `pc_plus4` plus the sign-extended 16-bit `imm_ofs` multiplied by four. This holds for every instruction kind and in every hazard condition.
- R2: `jmp_target` always equals bits 31..28 of `pc_plus4` above `jmp_index`, followed by two zero bits.
- R3: A branch that is taken and not stalled gives `pc_sel` = 1, `if_flush` = 1, `pc_wen` = 1, `ifid_wen` = 1 and `idex_bubble` = 0. A branch is taken when `is_beq` is set and its operands are equal, or when `is_bne` is set and they differ.
- R4: When `is_jump` is set, the block gives `pc_sel` = 2, `if_flush` = 1, `pc_wen` = 1, `ifid_wen` = 1 and `idex_bubble` = 0. A jump never stalls, and it takes precedence over the branch flags.
- R5: A branch that is not taken, or an instruction that is neither a branch nor a jump, gives `pc_sel` = 0, `if_flush` = 0, `pc_wen` = 1, `ifid_wen` = 1 and `idex_bubble` = 0.
- R6: A branch stalls when `ex_wen` is set and `ex_dst` is non-zero and equals `src_a` or `src_b`. A stall gives `pc_wen` = 0, `ifid_wen` = 0, `idex_bubble` = 1, `if_flush` = 0 and `pc_sel` = 0, whatever the comparison would give.
- R7: A branch also stalls as in R6 when `mem_wen` and `mem_is_load` are set and `mem_dst` is non-zero and equals `src_a` or `src_b`. A load feeding a branch is therefore held while it is in execute and again while it is in memory. The branch resolves once the load reaches write-back.
- R8: When `mem_wen` is set, `mem_is_load` is clear and `mem_dst` is non-zero and equal to a source register, the comparison uses `mem_result` in place of that operand's register-file data.
- R9: Register 0 never causes a stall or a forward. A source index of 0 always compares the register-file data.
- R10: Producer matches have no effect unless a branch is being decoded. In that case the PC and the fetch/decode register keep advancing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_plus4 | input | 32 | Sequential PC of the instruction in decode |
| is_beq | input | 1 | Decode holds a branch-if-equal |
| is_bne | input | 1 | Decode holds a branch-if-not-equal |
| is_jump | input | 1 | Decode holds a direct jump |
| src_a | input | REG_AW | First branch source register index |
| src_b | input | REG_AW | Second branch source register index |
| imm_ofs | input | 16 | Branch word offset from the instruction |
| jmp_index | input | 26 | Jump word index from the instruction |
| rf_data_a | input | DATA_W | Register-file read data for `src_a` |
| rf_data_b | input | DATA_W | Register-file read data for `src_b` |
| ex_dst | input | REG_AW | Destination register of the instruction in execute |
| ex_wen | input | 1 | Instruction in execute writes a register |
| mem_dst | input | REG_AW | Destination register of the instruction in memory |
| mem_wen | input | 1 | Instruction in memory writes a register |
| mem_is_load | input | 1 | Instruction in memory is a load |
| mem_result | input | DATA_W | ALU result held in the memory stage |
| pc_wen | output | 1 | PC write enable |
| ifid_wen | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Zero the control bits entering decode/execute |
| if_flush | output | 1 | Replace the fetched instruction with a no-op |
| pc_sel | output | 2 | Next-PC source: 0 sequential, 1 branch, 2 jump |
| br_target | output | 32 | Branch destination address |
| jmp_target | output | 32 | Jump destination address |

## Verification
Every output depends only on the present inputs, so a wrong internal decision shows at the ports in the same cycle. A forwarding selection that is wrong shows as a flipped taken or not-taken result on `pc_sel` and `if_flush`. A hazard match that is missed shows as a branch resolved on stale data instead of a frozen `pc_wen`. A false match shows as a lost cycle with `idex_bubble` raised. The bench models the pipeline stages around the block. It drives ALU and load producers a set distance ahead of the branch, including a load that moves from execute to memory to write-back. It checks that each step holds or releases the branch as the producer advances.

// File: rtl/idbr_pkg.sv
package idbr_pkg;

  localparam int PC_W  = 32;
  localparam int OFS_W = 16;
  localparam int IDX_W = 26;
  localparam int HI_W  = PC_W - IDX_W - 2;

  typedef enum logic [1:0] {
    PCSEL_SEQ    = 2'd0,
    PCSEL_BRANCH = 2'd1,
    PCSEL_JUMP   = 2'd2
  } pcsel_e;

  // Sign-extend the word offset, scale to bytes, add to sequential PC.
  function automatic logic [PC_W-1:0] branch_dest(
    input logic [PC_W-1:0]  seq_pc,
    input logic [OFS_W-1:0] ofs
  );
    logic [PC_W-1:0] disp;
    disp = {{(PC_W-OFS_W-2){ofs[OFS_W-1]}}, ofs, 2'b00};
    return seq_pc + disp;
  endfunction

  // Region bits of the sequential PC above the scaled word index.
  function automatic logic [PC_W-1:0] jump_dest(
    input logic [PC_W-1:0]  seq_pc,
    input logic [IDX_W-1:0] idx
  );
    return {seq_pc[PC_W-1 -: HI_W], idx, 2'b00};
  endfunction

endpackage

// File: rtl/idbr_src_path.sv
module idbr_src_path #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [DATA_W-1:0] rf_data,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wen,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wen,
  input  logic              mem_is_load,
  input  logic [DATA_W-1:0] mem_result,
  output logic [DATA_W-1:0] value,
  output logic              need_hold,
  output logic              use_fwd
);

  logic src_live;
  logic ex_hit;
  logic mem_hit;

  assign src_live  = (src != '0);
  assign ex_hit    = src_live && ex_wen && (ex_dst == src);
  assign mem_hit   = src_live && mem_wen && (mem_dst == src);

  // Anything in execute, or a load still in memory, is not ready yet.
  assign need_hold = ex_hit || (mem_hit && mem_is_load);
  assign use_fwd   = mem_hit && !mem_is_load;
  assign value     = use_fwd ? mem_result : rf_data;

endmodule

// File: rtl/idbr_decide.sv
module idbr_decide #(
  parameter int DATA_W = 32
) (
  input  logic              is_beq,
  input  logic              is_bne,
  input  logic              is_jump,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              hold_a,
  input  logic              hold_b,
  output logic              pc_wen,
  output logic              ifid_wen,
  output logic              idex_bubble,
  output logic              if_flush,
  output logic [1:0]        pc_sel,
  output logic              stall,
  output logic              taken
);
  import idbr_pkg::*;

  logic is_branch;
  logic same;

  assign is_branch = (is_beq || is_bne) && !is_jump;
  assign same      = (opnd_a == opnd_b);
  assign stall     = is_branch && (hold_a || hold_b);
  assign taken     = is_branch && ((is_beq && same) || (is_bne && !same));

  always_comb begin
    pc_wen      = 1'b1;
    ifid_wen    = 1'b1;
    idex_bubble = 1'b0;
    if_flush    = 1'b0;
    pc_sel      = PCSEL_SEQ;
    if (is_jump) begin
      if_flush = 1'b1;
      pc_sel   = PCSEL_JUMP;
    end else if (stall) begin
      pc_wen      = 1'b0;
      ifid_wen    = 1'b0;
      idex_bubble = 1'b1;
    end else if (taken) begin
      if_flush = 1'b1;
      pc_sel   = PCSEL_BRANCH;
    end
  end

endmodule

// File: rtl/id_branch_unit.sv
module id_branch_unit #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic [31:0]       pc_plus4,
  input  logic              is_beq,
  input  logic              is_bne,
  input  logic              is_jump,
  input  logic [REG_AW-1:0] src_a,
  input  logic [REG_AW-1:0] src_b,
  input  logic [15:0]       imm_ofs,
  input  logic [25:0]       jmp_index,
  input  logic [DATA_W-1:0] rf_data_a,
  input  logic [DATA_W-1:0] rf_data_b,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wen,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wen,
  input  logic              mem_is_load,
  input  logic [DATA_W-1:0] mem_result,
  output logic              pc_wen,
  output logic              ifid_wen,
  output logic              idex_bubble,
  output logic              if_flush,
  output logic [1:0]        pc_sel,
  output logic [31:0]       br_target,
  output logic [31:0]       jmp_target
);
  import idbr_pkg::*;

  localparam int NSRC = 2;

  logic [REG_AW-1:0] src_idx [NSRC];
  logic [DATA_W-1:0] src_rf  [NSRC];
  logic [DATA_W-1:0] src_val [NSRC];
  logic [NSRC-1:0]   src_hold;
  logic [NSRC-1:0]   src_fwd;

  // Named internal events for the checker.
  logic stall_w;
  logic taken_w;

  assign src_idx[0] = src_a;
  assign src_idx[1] = src_b;
  assign src_rf[0]  = rf_data_a;
  assign src_rf[1]  = rf_data_b;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      idbr_src_path #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_path (
        .src         (src_idx[g]),
        .rf_data     (src_rf[g]),
        .ex_dst      (ex_dst),
        .ex_wen      (ex_wen),
        .mem_dst     (mem_dst),
        .mem_wen     (mem_wen),
        .mem_is_load (mem_is_load),
        .mem_result  (mem_result),
        .value       (src_val[g]),
        .need_hold   (src_hold[g]),
        .use_fwd     (src_fwd[g])
      );
    end
  endgenerate

  idbr_decide #(.DATA_W(DATA_W)) u_decide (
    .is_beq      (is_beq),
    .is_bne      (is_bne),
    .is_jump     (is_jump),
    .opnd_a      (src_val[0]),
    .opnd_b      (src_val[1]),
    .hold_a      (src_hold[0]),
    .hold_b      (src_hold[1]),
    .pc_wen      (pc_wen),
    .ifid_wen    (ifid_wen),
    .idex_bubble (idex_bubble),
    .if_flush    (if_flush),
    .pc_sel      (pc_sel),
    .stall       (stall_w),
    .taken       (taken_w)
  );

  // Both destinations are formed for every instruction, in parallel with the read.
  assign br_target  = branch_dest(pc_plus4, imm_ofs);
  assign jmp_target = jump_dest(pc_plus4, jmp_index);

endmodule

// File: rtl/id_branch_unit_chk.sv
module id_branch_unit_chk #(
  parameter int REG_AW = 5
) (
  input logic              is_beq,
  input logic              is_bne,
  input logic              is_jump,
  input logic [REG_AW-1:0] src_a,
  input logic [REG_AW-1:0] src_b,
  input logic [REG_AW-1:0] mem_dst,
  input logic              mem_wen,
  input logic              mem_is_load,
  input logic              pc_wen,
  input logic              ifid_wen,
  input logic              idex_bubble,
  input logic              if_flush,
  input logic [1:0]        pc_sel,
  input logic              stall_w,
  input logic              taken_w
);

  logic br_now;
  logic load_feeds;

  assign br_now     = (is_beq || is_bne) && !is_jump;
  assign load_feeds = mem_wen && mem_is_load && (mem_dst != '0) &&
                      ((mem_dst == src_a) || (mem_dst == src_b));

  always_comb begin
    AST_STALL_FREEZES: assert (!stall_w || (!pc_wen && !ifid_wen && idex_bubble && !if_flush)) else $error("stall did not freeze"); // R6
    AST_FLUSH_REDIRECTS: assert (!if_flush || (pc_wen && pc_sel != 2'd0)) else $error("flush without redirect"); // R3
    AST_TAKEN_SELECTS: assert (!(taken_w && !stall_w && !is_jump) || pc_sel == 2'd1) else $error("taken branch not selected"); // R3
    AST_JUMP_WINS: assert (!is_jump || (pc_sel == 2'd2 && pc_wen && !idex_bubble)) else $error("jump not taken"); // R4
    AST_SEL_LEGAL: assert (pc_sel != 2'd3) else $error("illegal pc_sel"); // R5
    AST_LOAD_IN_MEM_HOLDS: assert (!(br_now && load_feeds) || !pc_wen) else $error("load in memory not held"); // R7
    AST_ZERO_NEVER_HOLDS: assert (!(src_a == '0 && src_b == '0) || pc_wen) else $error("register 0 stalled"); // R9
    AST_NON_BRANCH_FLOWS: assert (is_beq || is_bne || pc_wen) else $error("non-branch stalled"); // R10
  end

endmodule

bind id_branch_unit id_branch_unit_chk #(.REG_AW(REG_AW)) u_chk (
  .is_beq      (is_beq),
  .is_bne      (is_bne),
  .is_jump     (is_jump),
  .src_a       (src_a),
  .src_b       (src_b),
  .mem_dst     (mem_dst),
  .mem_wen     (mem_wen),
  .mem_is_load (mem_is_load),
  .pc_wen      (pc_wen),
  .ifid_wen    (ifid_wen),
  .idex_bubble (idex_bubble),
  .if_flush    (if_flush),
  .pc_sel      (pc_sel),
  .stall_w     (stall_w),
  .taken_w     (taken_w)
);

// File: tb/id_branch_unit_test.sv
module id_branch_unit_test;

  localparam int DW = 32;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [31:0]   pc_plus4;
  logic          is_beq, is_bne, is_jump;
  logic [RW-1:0] src_a, src_b, ex_dst, mem_dst;
  logic [15:0]   imm_ofs;
  logic [25:0]   jmp_index;
  logic [DW-1:0] rf_data_a, rf_data_b, mem_result;
  logic          ex_wen, mem_wen, mem_is_load;
  logic          pc_wen, ifid_wen, idex_bubble, if_flush;
  logic [1:0]    pc_sel;
  logic [31:0]   br_target, jmp_target;

  id_branch_unit #(.DATA_W(DW), .REG_AW(RW)) uut (
    .pc_plus4(pc_plus4), .is_beq(is_beq), .is_bne(is_bne), .is_jump(is_jump),
    .src_a(src_a), .src_b(src_b), .imm_ofs(imm_ofs), .jmp_index(jmp_index),
    .rf_data_a(rf_data_a), .rf_data_b(rf_data_b), .ex_dst(ex_dst), .ex_wen(ex_wen),
    .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_is_load(mem_is_load),
    .mem_result(mem_result), .pc_wen(pc_wen), .ifid_wen(ifid_wen),
    .idex_bubble(idex_bubble), .if_flush(if_flush), .pc_sel(pc_sel),
    .br_target(br_target), .jmp_target(jmp_target)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Model: operand as seen by the comparator.
  function automatic logic [DW-1:0] m_operand(input logic [RW-1:0] s, input logic [DW-1:0] rf);
    if (s != 0 && mem_wen && !mem_is_load && mem_dst == s) return mem_result;
    return rf;
  endfunction

  function automatic bit m_not_ready(input logic [RW-1:0] s);
    if (s == 0) return 0;
    if (ex_wen && ex_dst == s) return 1;
    if (mem_wen && mem_is_load && mem_dst == s) return 1;
    return 0;
  endfunction

  // Expected {pc_wen, ifid_wen, idex_bubble, if_flush, pc_sel}.
  function automatic logic [5:0] m_ctrl();
    bit br, eq, tk;
    br = (is_beq | is_bne);
    if (is_jump) return 6'b11_0_1_10;
    if (br && (m_not_ready(src_a) || m_not_ready(src_b))) return 6'b00_1_0_00;
    eq = (m_operand(src_a, rf_data_a) == m_operand(src_b, rf_data_b));
    tk = br && (is_beq ? eq : !eq);
    return tk ? 6'b11_0_1_01 : 6'b11_0_0_00;
  endfunction

  function automatic string m_tag();
    bit eq;
    if (is_jump) return "R4";
    if (!(is_beq | is_bne)) return "R10";
    if (m_not_ready(src_a) || m_not_ready(src_b)) begin
      if ((ex_wen && ex_dst != 0 && (ex_dst == src_a || ex_dst == src_b))) return "R6";
      return "R7";
    end
    if ((src_a != 0 && mem_wen && !mem_is_load && mem_dst == src_a) ||
        (src_b != 0 && mem_wen && !mem_is_load && mem_dst == src_b)) return "R8";
    eq = (rf_data_a == rf_data_b);
    if ((is_beq && eq) || (is_bne && !eq)) return "R3";
    return "R5";
  endfunction

  task automatic check_all(input string tag);
    logic [31:0] eb, ej;
    eb = pc_plus4 + 32'($signed(imm_ofs)) * 32'd4;
    ej = (pc_plus4 & 32'hF000_0000) | (32'(jmp_index) << 2);
    check(tag, 64'({pc_wen, ifid_wen, idex_bubble, if_flush, pc_sel}), 64'(m_ctrl()));
    check("R1", 64'(br_target), 64'(eb));
    check("R2", 64'(jmp_target), 64'(ej));
  endtask

  task automatic idle();
    pc_plus4 = 32'h0000_1000; is_beq = 0; is_bne = 0; is_jump = 0;
    src_a = 0; src_b = 0; imm_ofs = 0; jmp_index = 0;
    rf_data_a = 0; rf_data_b = 0; ex_dst = 0; ex_wen = 0;
    mem_dst = 0; mem_wen = 0; mem_is_load = 0; mem_result = 0;
  endtask

  task automatic step(input string tag);
    #2;
    check_all(tag);
    @(negedge clk);
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // Quiet inputs: sequential flow.
    #2;
    check("R5 idle", 64'({pc_wen, ifid_wen, idex_bubble, if_flush, pc_sel}), 64'(6'b11_0_0_00));
    @(negedge clk);

    // Target corner cases.
    idle(); pc_plus4 = 32'h0000_0100; imm_ofs = 16'hFFFF; step("R1");
    check("R1 neg", 64'(br_target), 64'h0000_00FC);
    idle(); pc_plus4 = 32'hA000_0010; jmp_index = 26'h3FF_FFFF; is_jump = 1; step("R4");
    check("R2 top", 64'(jmp_target), 64'hAFFF_FFFC);

    // Taken beq, bne not taken, bne taken.
    idle(); is_beq = 1; src_a = 4; src_b = 6; rf_data_a = 55; rf_data_b = 55; step("R3");
    idle(); is_bne = 1; src_a = 4; src_b = 6; rf_data_a = 55; rf_data_b = 55; step("R5");
    idle(); is_bne = 1; src_a = 4; src_b = 6; rf_data_a = 55; rf_data_b = 56; step("R3");

    // Load feeding branch: execute, then memory, then write-back.
    idle(); is_beq = 1; src_a = 5; src_b = 7; rf_data_a = 9; rf_data_b = 9;
    ex_dst = 5; ex_wen = 1; step("R6");
    check("R6 hold", 64'(pc_wen), 64'(0));
    ex_wen = 0; ex_dst = 0; mem_dst = 5; mem_wen = 1; mem_is_load = 1; mem_result = 1; step("R7");
    check("R7 hold", 64'(idex_bubble), 64'(1));
    mem_wen = 0; mem_dst = 0; mem_is_load = 0; step("R3");
    check("R3 after load", 64'(pc_sel), 64'(1));

    // Stall beats a branch that would be taken.
    idle(); is_beq = 1; src_a = 3; src_b = 3; rf_data_a = 1; rf_data_b = 1;
    ex_dst = 3; ex_wen = 1; step("R6");
    check("R6 no flush", 64'(if_flush), 64'(0));

    // Forwarding from memory.
    idle(); is_beq = 1; src_a = 3; src_b = 8; rf_data_a = 7; rf_data_b = 9;
    mem_dst = 3; mem_wen = 1; mem_result = 9; step("R8");
    check("R8 fwd a", 64'(pc_sel), 64'(1));
    idle(); is_bne = 1; src_a = 3; src_b = 8; rf_data_a = 7; rf_data_b = 9;
    mem_dst = 8; mem_wen = 1; mem_result = 7; step("R8");
    check("R8 fwd b", 64'(if_flush), 64'(0));

    // Register 0.
    idle(); is_beq = 1; src_a = 0; src_b = 2; rf_data_a = 4; rf_data_b = 4;
    ex_dst = 0; ex_wen = 1; mem_dst = 0; mem_wen = 1; mem_is_load = 1; step("R9");
    check("R9 no stall", 64'(pc_wen), 64'(1));
    idle(); is_beq = 1; src_a = 0; src_b = 0; rf_data_a = 0; rf_data_b = 0;
    mem_dst = 0; mem_wen = 1; mem_result = 32'hDEAD; step("R9");
    check("R9 no fwd", 64'(pc_sel), 64'(1));

    // Producers without a branch.
    idle(); src_a = 6; src_b = 6; ex_dst = 6; ex_wen = 1; step("R10");
    check("R10 flows", 64'({pc_wen, ifid_wen}), 64'(2'b11));
    idle(); is_jump = 1; src_a = 6; ex_dst = 6; ex_wen = 1; step("R4");
    check("R4 no stall", 64'(pc_wen), 64'(1));

    // Constrained random mix.
    for (int i = 0; i < 600; i++) begin
      int kind;
      idle();
      kind        = $urandom_range(0, 9);
      is_jump     = (kind == 0);
      is_beq      = (kind >= 1 && kind <= 4);
      is_bne      = (kind >= 5 && kind <= 8);
      pc_plus4    = $urandom & 32'hFFFF_FFFC;
      imm_ofs     = 16'($urandom);
      jmp_index   = 26'($urandom);
      src_a       = RW'($urandom_range(0, 3));
      src_b       = RW'($urandom_range(0, 3));
      rf_data_a   = DW'($urandom_range(0, 2));
      rf_data_b   = DW'($urandom_range(0, 2));
      ex_dst      = RW'($urandom_range(0, 5));
      ex_wen      = ($urandom_range(0, 2) == 0);
      mem_dst     = RW'($urandom_range(0, 5));
      mem_wen     = ($urandom_range(0, 1) == 0);
      mem_is_load = ($urandom_range(0, 2) == 0);
      mem_result  = DW'($urandom_range(0, 2));
      step(m_tag());
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule